// File: doc/BRIEF.md
# Reordering Word-Input Message Buffer

This block sits in front of a variable-length block cipher datapath. It gathers one message of 2 to 8 words, 32 bits each, from a word-wide write port. It then presents all slots in parallel, so that slot i can feed working register i of the datapath with no further reordering. Two configuration inputs steer the loading. One sets how many words make up the block. The other selects the encrypt or decrypt direction.

In encrypt direction the words are placed in arrival order, starting at slot 0. In decrypt direction each arriving word is written to slot 0 and every stored word moves one slot higher. The block therefore ends up stored in reverse order, and the datapath can use one register order for both directions. When the last word of the block has been stored, a block-ready flag goes high. The flag stays high until the core gives a one-cycle accept pulse. While it is high, the write port holds its ready output low, so further words wait instead of being lost.

Top module: `msgbuf_reorder`

## Requirements
- R1: After reset, `blk_avail` is 0 and `wr_ready` is 1.
- R2: A word is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both 1. `blk_avail` goes to 1 right after the edge that accepts the Nth word of the block, where N is the effective word count, and stays 0 before that edge. Idle cycles between words are allowed.
- R3: The effective word count is `cfg_words` limited to the range 2 to 8. A value below 2 acts as 2 and a value above 8 acts as 8. `blk_count` reports the effective count.
- R4: When `cfg_decrypt` is 0 (encrypt), the k-th accepted word of a block (k counted from 0) ends up in slot k. Slot i is `blk_words[32*i +: 32]`.
- R5: When `cfg_decrypt` is 1 (decrypt), the k-th accepted word of an N-word block ends up in slot N-1-k.
- R6: `cfg_words` and `cfg_decrypt` are sampled only on the first accepted word of a block. Changes made later in the same block change neither the word count, the slot order, `blk_count` nor `blk_decrypt`.
- R7: Once high, `blk_avail` stays high until a cycle with `core_take` at 1. It is 0 right after that edge, and the next accepted word starts a new block.
- R8: While `blk_avail` is 1, `wr_ready` is 0 and the slot contents do not change. A write held pending during that time is accepted after the accept pulse, as the first word of the next block.
- R9: A `core_take` pulse while `blk_avail` is 0 has no effect. A partly filled block keeps its words and its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_words | input | 4 | Requested number of words per block |
| cfg_decrypt | input | 1 | Direction: 0 encrypt (in-order), 1 decrypt (reversed) |
| wr_valid | input | 1 | Word offered on `wr_data` |
| wr_data | input | 32 | Incoming message word |
| wr_ready | output | 1 | Buffer can take a word this cycle |
| core_take | input | 1 | One-cycle pulse: core has taken the block |
| blk_avail | output | 1 | Full block stored and waiting |
| blk_words | output | 256 | All slots, slot i at bits 32*i+31 down to 32*i |
| blk_count | output | 4 | Effective word count of the current or last block |
| blk_decrypt | output | 1 | Direction latched for the current or last block |

## Verification
Every result here is registered. A word placed on the port in one cycle is in its slot just after the next rising edge. `blk_avail` rises at the same edge as the last word of the block, and it falls at the edge that samples `core_take`. The bench changes inputs and reads outputs only on falling edges. Each word takes exactly one clock period, so every check falls half a period after the edge that should have produced its value. The stall and mid-block tests check the same outputs at several falling edges in a row. This shows that outputs which should not move stay put for the whole window.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;

   typedef enum logic {
      DIR_ENC = 1'b0,
      DIR_DEC = 1'b1
   } dir_e;

   // Limit a requested count to the supported window.
   function automatic int limit_count(input int req, input int lo, input int hi);
      if (req < lo)      return lo;
      else if (req > hi) return hi;
      else               return req;
   endfunction

endpackage

// File: rtl/msgbuf_ctrl.sv
module msgbuf_ctrl
   import msgbuf_pkg::*;
#(
   parameter int MIN_WORDS = 2,
   parameter int MAX_WORDS = 8,
   localparam int CNT_W = $clog2(MAX_WORDS + 1),
   localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_words,
   input  logic             cfg_decrypt,
   input  logic             wr_valid,
   input  logic             core_take,
   output logic             wr_fire,
   output logic             wr_ready,
   output logic [IDX_W-1:0] wr_idx,
   output dir_e             wr_dir,
   output logic             blk_avail,
   output logic [CNT_W-1:0] lat_words,
   output dir_e             lat_dir
);

   logic [IDX_W-1:0] fill_q;
   logic             avail_q;
   logic [CNT_W-1:0] words_q;
   dir_e             dir_q;

   logic             first_word;
   logic [CNT_W-1:0] eff_words;
   logic [CNT_W-1:0] next_fill;
   logic             last_word;

   assign wr_ready   = !avail_q;
   assign wr_fire    = wr_valid && wr_ready;
   assign first_word = (fill_q == '0);

   // Configuration is taken live only on the first word of a block.
   always_comb begin
      if (first_word) begin
         eff_words = CNT_W'(limit_count(int'(cfg_words), MIN_WORDS, MAX_WORDS));
         wr_dir    = cfg_decrypt ? DIR_DEC : DIR_ENC;
      end else begin
         eff_words = words_q;
         wr_dir    = dir_q;
      end
   end

   assign next_fill = CNT_W'(fill_q) + CNT_W'(1);
   assign last_word = (next_fill == eff_words);
   assign wr_idx    = fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q  <= '0;
         avail_q <= 1'b0;
         words_q <= CNT_W'(MIN_WORDS);
         dir_q   <= DIR_ENC;
      end else begin
         if (wr_fire) begin
            if (first_word) begin
               words_q <= eff_words;
               dir_q   <= wr_dir;
            end
            if (last_word) begin
               fill_q  <= '0;
               avail_q <= 1'b1;
            end else begin
               fill_q  <= IDX_W'(next_fill);
            end
         end else if (avail_q && core_take) begin
            avail_q <= 1'b0;
            fill_q  <= '0;
         end
      end
   end

   assign blk_avail = avail_q;
   assign lat_words = words_q;
   assign lat_dir   = dir_q;

endmodule

// File: rtl/msgbuf_slots.sv
module msgbuf_slots
   import msgbuf_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int MAX_WORDS   = 8,
   parameter bit RESET_SLOTS = 1'b1,
   localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
   localparam int FLAT_W = WORD_W * MAX_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [IDX_W-1:0]  wr_idx,
   input  dir_e              wr_dir,
   input  logic [WORD_W-1:0] wr_data,
   output logic [FLAT_W-1:0] slots_flat
);

   logic [WORD_W-1:0] slot_q [MAX_WORDS];
   logic [WORD_W-1:0] slot_d [MAX_WORDS];

   for (genvar i = 0; i < MAX_WORDS; i++) begin : g_slot
      // Next value: decrypt shifts up from slot 0, encrypt writes the indexed slot.
      if (i == 0) begin : g_head
         always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_fire) begin
               if (wr_dir == DIR_DEC)             slot_d[i] = wr_data;
               else if (wr_idx == IDX_W'(i))      slot_d[i] = wr_data;
            end
         end
      end else begin : g_body
         always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_fire) begin
               if (wr_dir == DIR_DEC)             slot_d[i] = slot_q[i-1];
               else if (wr_idx == IDX_W'(i))      slot_d[i] = wr_data;
            end
         end
      end

      if (RESET_SLOTS) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            slot_q[i] <= slot_d[i];
         end
      end

      assign slots_flat[i*WORD_W +: WORD_W] = slot_q[i];
   end

endmodule

// File: rtl/msgbuf_reorder.sv
module msgbuf_reorder
   import msgbuf_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int MIN_WORDS   = 2,
   parameter int MAX_WORDS   = 8,
   parameter bit RESET_SLOTS = 1'b1,
   localparam int CNT_W  = $clog2(MAX_WORDS + 1),
   localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
   localparam int FLAT_W = WORD_W * MAX_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_words,
   input  logic              cfg_decrypt,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              core_take,
   output logic              blk_avail,
   output logic [FLAT_W-1:0] blk_words,
   output logic [CNT_W-1:0]  blk_count,
   output logic              blk_decrypt
);

   if (WORD_W < 1) begin : g_bad_width
      $error("msgbuf_reorder: WORD_W must be positive");
   end
   if (MIN_WORDS < 1) begin : g_bad_min
      $error("msgbuf_reorder: MIN_WORDS must be at least 1");
   end
   if (MAX_WORDS < MIN_WORDS) begin : g_bad_max
      $error("msgbuf_reorder: MAX_WORDS must not be below MIN_WORDS");
   end

   logic             wr_fire;
   logic [IDX_W-1:0] wr_idx;
   dir_e             wr_dir;
   dir_e             lat_dir;

   msgbuf_ctrl #(
      .MIN_WORDS (MIN_WORDS),
      .MAX_WORDS (MAX_WORDS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_words   (cfg_words),
      .cfg_decrypt (cfg_decrypt),
      .wr_valid    (wr_valid),
      .core_take   (core_take),
      .wr_fire     (wr_fire),
      .wr_ready    (wr_ready),
      .wr_idx      (wr_idx),
      .wr_dir      (wr_dir),
      .blk_avail   (blk_avail),
      .lat_words   (blk_count),
      .lat_dir     (lat_dir)
   );

   msgbuf_slots #(
      .WORD_W      (WORD_W),
      .MAX_WORDS   (MAX_WORDS),
      .RESET_SLOTS (RESET_SLOTS)
   ) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_fire    (wr_fire),
      .wr_idx     (wr_idx),
      .wr_dir     (wr_dir),
      .wr_data    (wr_data),
      .slots_flat (blk_words)
   );

   assign blk_decrypt = (lat_dir == DIR_DEC);

endmodule

// File: rtl/msgbuf_checker.sv
module msgbuf_checker #(
   parameter int WORD_W    = 32,
   parameter int MIN_WORDS = 2,
   parameter int MAX_WORDS = 8,
   localparam int CNT_W  = $clog2(MAX_WORDS + 1),
   localparam int FLAT_W = WORD_W * MAX_WORDS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              core_take,
   input logic              blk_avail,
   input logic [FLAT_W-1:0] blk_words,
   input logic [CNT_W-1:0]  blk_count,
   input logic              blk_decrypt
);

   // R2: the flag can only rise on an edge that took a word.
   p_rise_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blk_avail) |-> $past(wr_valid && wr_ready));

   // R3: a stored block always carries a count in the supported range.
   p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_avail |-> (blk_count >= CNT_W'(MIN_WORDS) && blk_count <= CNT_W'(MAX_WORDS)));

   // R6: latched configuration does not move while the block waits.
   p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      blk_avail |=> ($stable(blk_count) && $stable(blk_decrypt)));

   // R7: the flag holds until accepted.
   p_hold_until_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_avail && !core_take) |=> blk_avail);

   // R7: an accept clears the flag.
   p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_avail && core_take) |=> !blk_avail);

   // R8: a waiting block is never overwritten.
   p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      blk_avail |=> $stable(blk_words));

endmodule

bind msgbuf_reorder msgbuf_checker #(
   .WORD_W    (WORD_W),
   .MIN_WORDS (MIN_WORDS),
   .MAX_WORDS (MAX_WORDS)
) u_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .core_take   (core_take),
   .blk_avail   (blk_avail),
   .blk_words   (blk_words),
   .blk_count   (blk_count),
   .blk_decrypt (blk_decrypt)
);

// File: tb/msgbuf_reorder_bench.sv
module msgbuf_reorder_bench;

   localparam int W  = 32;
   localparam int MX = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    cfg_words = 4'd2;
   logic          cfg_decrypt = 1'b0;
   logic          wr_valid = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic          wr_ready;
   logic          core_take = 1'b0;
   logic          blk_avail;
   logic [W*MX-1:0] blk_words;
   logic [3:0]    blk_count;
   logic          blk_decrypt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [W-1:0] sent [MX];

   always #5 clk = ~clk;

   msgbuf_reorder u_msgbuf_reorder (
      .clk(clk), .rst_n(rst_n), .cfg_words(cfg_words), .cfg_decrypt(cfg_decrypt),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .core_take(core_take), .blk_avail(blk_avail), .blk_words(blk_words),
      .blk_count(blk_count), .blk_decrypt(blk_decrypt)
   );

   task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // All tasks start and end just after a falling edge.
   task automatic push(input logic [W-1:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic take();
      core_take = 1'b1;
      @(negedge clk);
      core_take = 1'b0;
   endtask

   // Compare slots against words sent, in forward or reversed order.
   task automatic check_slots(input string req, input int n, input bit rev);
      for (int i = 0; i < n; i++) begin
         check(req, $sformatf("slot %0d", i), blk_words[i*W +: W], rev ? sent[n-1-i] : sent[i]);
      end
   endtask

   task automatic fill_block(input string req, input int n, input bit rev, input logic [7:0] tag);
      for (int k = 0; k < n; k++) begin
         sent[k] = {tag, 8'h5A, 8'(k), 8'(k * 17 + 3)};
         if (k == n - 1) check("R2", "avail before last word", W'(blk_avail), W'(0));
         push(sent[k]);
      end
      check("R2", "avail after last word", W'(blk_avail), W'(1));
      check(req, "blk_count", W'(blk_count), W'(n));
      check("R6", "blk_decrypt", W'(blk_decrypt), W'(rev));
      check_slots(req, n, rev);
   endtask

   task automatic t_reset();
      check("R1", "avail at reset", W'(blk_avail), W'(0));
      check("R1", "ready at reset", W'(wr_ready), W'(1));
   endtask

   task automatic t_encrypt(input int n);
      cfg_words = 4'(n); cfg_decrypt = 1'b0;
      fill_block("R4", n, 1'b0, 8'hE0 + 8'(n));
      repeat (2) @(negedge clk);
      check("R7", "avail holds", W'(blk_avail), W'(1));
      take();
      check("R7", "avail cleared", W'(blk_avail), W'(0));
      check("R7", "ready back", W'(wr_ready), W'(1));
   endtask

   task automatic t_decrypt(input int n);
      cfg_words = 4'(n); cfg_decrypt = 1'b1;
      fill_block("R5", n, 1'b1, 8'hD0 + 8'(n));
      take();
      check("R7", "avail cleared", W'(blk_avail), W'(0));
   endtask

   task automatic t_clamp();
      cfg_words = 4'd1; cfg_decrypt = 1'b0;
      fill_block("R3", 2, 1'b0, 8'hC1);
      take();
      cfg_words = 4'd15; cfg_decrypt = 1'b1;
      fill_block("R3", 8, 1'b1, 8'hCF);
      take();
      cfg_words = 4'd0; cfg_decrypt = 1'b0;
      fill_block("R3", 2, 1'b0, 8'hC0);
      take();
   endtask

   task automatic t_midchange();
      cfg_words = 4'd4; cfg_decrypt = 1'b0;
      for (int k = 0; k < 4; k++) begin
         sent[k] = 32'h6000_0000 + 32'(k);
         push(sent[k]);
         cfg_words = 4'd7; cfg_decrypt = 1'b1;
      end
      check("R6", "avail after 4 words", W'(blk_avail), W'(1));
      check("R6", "blk_count latched", W'(blk_count), W'(4));
      check("R6", "blk_decrypt latched", W'(blk_decrypt), W'(0));
      check_slots("R6", 4, 1'b0);
      take();
   endtask

   task automatic t_stall();
      logic [W*MX-1:0] snap;
      cfg_words = 4'd3; cfg_decrypt = 1'b0;
      fill_block("R4", 3, 1'b0, 8'h5B);
      snap = blk_words;
      cfg_words = 4'd2; cfg_decrypt = 1'b1;
      wr_valid = 1'b1; wr_data = 32'hBEEF_0001;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R8", "ready low while full", W'(wr_ready), W'(0));
         check("R8", "slots frozen", W'(blk_words == snap), W'(1));
      end
      core_take = 1'b1;
      @(negedge clk);
      core_take = 1'b0;
      check("R8", "avail clear after take", W'(blk_avail), W'(0));
      @(negedge clk);
      wr_valid = 1'b0;
      check("R8", "pending word in new block", W'(blk_avail), W'(0));
      sent[0] = 32'hBEEF_0001;
      sent[1] = 32'hBEEF_0002;
      push(sent[1]);
      check("R8", "avail after pending block", W'(blk_avail), W'(1));
      check_slots("R8", 2, 1'b1);
      take();
   endtask

   task automatic t_idle_take();
      cfg_words = 4'd3; cfg_decrypt = 1'b1;
      sent[0] = 32'h7700_0000;
      push(sent[0]);
      take();
      check("R9", "idle take no flag", W'(blk_avail), W'(0));
      sent[1] = 32'h7700_0001;
      push(sent[1]);
      check("R9", "still partial", W'(blk_avail), W'(0));
      sent[2] = 32'h7700_0002;
      push(sent[2]);
      check("R9", "block completes at 3", W'(blk_avail), W'(1));
      check_slots("R9", 3, 1'b1);
      take();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_encrypt(2);
      t_encrypt(5);
      t_encrypt(8);
      t_decrypt(2);
      t_decrypt(3);
      t_decrypt(8);
      t_clamp();
      t_midchange();
      t_stall();
      t_idle_take();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule